// File: doc/BRIEF.md
# Banked Low-Power Single-Port RAM

This block is a single-port synchronous RAM whose storage is split across several smaller banks so that an access wakes only the bank that holds the addressed word. This cuts the dynamic power of the array. The upper address bits are decoded into one-hot bank enables. A registered copy of those bits steers an output multiplexer, which returns the word from the bank read on the previous cycle. A per-bank enable output lets a testbench or a power monitor watch the activity of each bank.

A parameter sets the bank depth limit. The bank count is the total depth divided by that limit, and the select width follows from the bank count. A second mode, chosen by parameter, slices the array by width instead. In that mode there is one single-bit bank per data bit, every bank is enabled on every access, and the read data is the concatenation of the bank outputs with no multiplexer. Elaboration stops if the total depth is not a power of two or is not a multiple of the bank depth limit.

Top module: `banked_ram`

## Requirements
- R1: With default parameters the RAM holds 4096 words of 4 bits in four banks of 1024 words. Every written word reads back unchanged.
- R2: In depth mode, while `ce` is high, `bank_en` is one-hot and bit k is set where k is the value of `addr[11:10]` (the top two address bits with the default bank depth limit).
- R3: While `ce` is low, `bank_en` is all zero, a high `we` writes nothing, and `rdata` keeps its value.
- R4: A write changes only the addressed word. Words at the same in-bank offset in the other banks are untouched.
- R5: A read (`ce`=1, `we`=0) at a clock edge puts the addressed word on `rdata` after that edge, with a latency of one cycle.
- R6: `rdata` changes only after a read cycle. Write cycles and idle cycles leave it unchanged.
- R7: While `rst_n` is low at a clock edge, `rdata` becomes zero after that edge.
- R8: The bank count is the total depth divided by the bank depth limit. With a limit of 512, there are eight banks, the select is `addr[11:9]`, and data still reads back correctly.
- R9: In width-sliced mode, `bank_en` is all ones while `ce` is high and all zeros otherwise, and reads return the stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset of the read path registers |
| ce | input | 1 | Access enable |
| we | input | 1 | Write when high, read when low (qualified by `ce`) |
| addr | input | ADDR_W (12) | Word address |
| wdata | input | DATA_W (4) | Write data |
| rdata | output | DATA_W (4) | Registered read data |
| bank_en | output | NUM_BANKS (4) | Per-bank enable for the current cycle |

## Verification
A fault in the decoder shows on `bank_en` in the same cycle as the access: the bit pattern is not one-hot, the wrong bit is set, or a bit is set while `ce` is low. A stale or wrong registered select shows on `rdata` one cycle after a read, as a word taken from another bank at the same offset. A write that reaches the wrong bank shows only on the first later read of the damaged word. For this reason every word is written and read back before the random phase starts. Hold faults show on `rdata` in the first write or idle cycle after a read.

// File: rtl/banked_ram_pkg.sv
package banked_ram_pkg;

    typedef enum logic {
        SPLIT_DEPTH = 1'b0,
        SPLIT_WIDTH = 1'b1
    } bank_mode_e;

    function automatic bit is_pow2(input int v);
        return (v > 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/bank_decoder.sv
module bank_decoder
    import banked_ram_pkg::*;
#(
    parameter int         NUM_BANKS = 4,
    parameter int         SEL_W     = 2,
    parameter bank_mode_e MODE      = SPLIT_DEPTH
) (
    input  logic                 ce,
    input  logic [SEL_W-1:0]     sel_in,
    output logic [NUM_BANKS-1:0] bank_en
);

    generate
        if (MODE == SPLIT_WIDTH) begin : g_width
            // every slice takes part in every access
            assign bank_en = {NUM_BANKS{ce}};
        end else begin : g_depth
            // one-hot enable of the bank addressed by the select bits
            assign bank_en = ce ? (NUM_BANKS'(1) << sel_in) : '0;
        end
    endgenerate

endmodule

// File: rtl/ram_bank.sv
module ram_bank #(
    parameter int WORDS = 1024,
    parameter int WIDTH = 4,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             we,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);

    typedef struct packed {
        logic [WIDTH-1:0] rd;
    } bank_st_t;

    logic [WIDTH-1:0] mem [WORDS];
    bank_st_t         st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en && !we) begin
            st_d.rd = mem[addr];
        end
    end

    // storage: write only when this bank is the one enabled
    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[addr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rd;

endmodule

// File: rtl/read_mux.sv
module read_mux
    import banked_ram_pkg::*;
#(
    parameter int         NUM_BANKS = 4,
    parameter int         BANK_W    = 4,
    parameter int         DATA_W    = 4,
    parameter int         SEL_W     = 2,
    parameter bank_mode_e MODE      = SPLIT_DEPTH
) (
    input  logic [NUM_BANKS*BANK_W-1:0] rd_flat,
    input  logic [SEL_W-1:0]            sel_q,
    output logic [DATA_W-1:0]           rdata
);

    generate
        if (MODE == SPLIT_WIDTH) begin : g_concat
            // one bit per slice, already in data-bit order
            assign rdata = rd_flat;
        end else begin : g_select
            assign rdata = rd_flat[sel_q*BANK_W +: BANK_W];
        end
    endgenerate

endmodule

// File: rtl/banked_ram.sv
module banked_ram
    import banked_ram_pkg::*;
#(
    parameter int          DATA_W      = 4,
    parameter int          TOTAL_DEPTH = 4096,
    parameter int          MAX_DEPTH   = 1024,
    parameter bank_mode_e  MODE        = SPLIT_DEPTH,
    localparam int         ADDR_W      = $clog2(TOTAL_DEPTH),
    localparam int         NUM_BANKS   = (MODE == SPLIT_WIDTH) ? DATA_W : TOTAL_DEPTH / MAX_DEPTH
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ce,
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata,
    output logic [NUM_BANKS-1:0] bank_en
);

    localparam int BANK_WORDS = (MODE == SPLIT_WIDTH) ? TOTAL_DEPTH : MAX_DEPTH;
    localparam int BANK_W     = (MODE == SPLIT_WIDTH) ? 1 : DATA_W;
    localparam int BANK_AW    = $clog2(BANK_WORDS);
    localparam int SEL_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    generate
        if (!is_pow2(TOTAL_DEPTH) || !is_pow2(MAX_DEPTH) ||
            (MAX_DEPTH > TOTAL_DEPTH) || ((TOTAL_DEPTH % MAX_DEPTH) != 0)) begin : g_bad_cfg
            $error("banked_ram: depth must be a power of two and a multiple of the bank depth");
        end
    endgenerate

    typedef struct packed {
        logic [SEL_W-1:0] sel;
    } top_st_t;

    top_st_t                     st_d, st_q;
    logic [SEL_W-1:0]            sel_in;
    logic [NUM_BANKS*BANK_W-1:0] rd_flat;

    generate
        if (MODE == SPLIT_DEPTH && NUM_BANKS > 1) begin : g_sel_bits
            assign sel_in = addr[ADDR_W-1 -: SEL_W];
        end else begin : g_sel_zero
            assign sel_in = '0;
        end
    endgenerate

    bank_decoder #(
        .NUM_BANKS (NUM_BANKS),
        .SEL_W     (SEL_W),
        .MODE      (MODE)
    ) i_bank_decoder (
        .ce      (ce),
        .sel_in  (sel_in),
        .bank_en (bank_en)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic [BANK_W-1:0] bank_wd;
            if (MODE == SPLIT_WIDTH) begin : g_wd_bit
                assign bank_wd = wdata[b];
            end else begin : g_wd_word
                assign bank_wd = wdata;
            end
            ram_bank #(
                .WORDS (BANK_WORDS),
                .WIDTH (BANK_W)
            ) i_ram_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (bank_en[b]),
                .we    (we),
                .addr  (addr[BANK_AW-1:0]),
                .wdata (bank_wd),
                .rdata (rd_flat[b*BANK_W +: BANK_W])
            );
        end
    endgenerate

    // the select follows reads only, so writes and idle cycles keep rdata
    always_comb begin
        st_d = st_q;
        if (ce && !we) begin
            st_d.sel = sel_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    read_mux #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .DATA_W    (DATA_W),
        .SEL_W     (SEL_W),
        .MODE      (MODE)
    ) i_read_mux (
        .rd_flat (rd_flat),
        .sel_q   (st_q.sel),
        .rdata   (rdata)
    );

endmodule

// File: rtl/banked_ram_checker.sv
module banked_ram_checker
    import banked_ram_pkg::*;
#(
    parameter int         DATA_W    = 4,
    parameter int         NUM_BANKS = 4,
    parameter bank_mode_e MODE      = SPLIT_DEPTH
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ce,
    input logic                 we,
    input logic [DATA_W-1:0]    rdata,
    input logic [NUM_BANKS-1:0] bank_en
);

    // R3: no bank wakes up without an access
    a_r3_idle_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |-> (bank_en == '0));

    // R6: read data moves only after a read cycle
    a_r6_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        !(ce && !we) |=> $stable(rdata));

    // R7: reset clears the read data
    a_r7_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (rdata == '0));

    generate
        if (MODE == SPLIT_WIDTH) begin : g_width_chk
            // R9: all slices active on an access
            a_r9_all_slices: assert property (@(posedge clk) disable iff (!rst_n)
                ce |-> (&bank_en));
        end else begin : g_depth_chk
            // R2: exactly one bank active on an access
            a_r2_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
                ce |-> ($countones(bank_en) == 1));
        end
    endgenerate

endmodule

bind banked_ram banked_ram_checker #(
    .DATA_W    (DATA_W),
    .NUM_BANKS (NUM_BANKS),
    .MODE      (MODE)
) i_banked_ram_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce      (ce),
    .we      (we),
    .rdata   (rdata),
    .bank_en (bank_en)
);

// File: tb/test_banked_ram.sv
`timescale 1ns/1ps
module test_banked_ram;
    import banked_ram_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [3:0]  wdata = '0;
    logic [3:0]  rd_a, rd_b, rd_c;
    logic [3:0]  en_a;
    logic [7:0]  en_b;
    logic [3:0]  en_c;

    logic [3:0]  model [4096];
    logic [3:0]  exp_rd = '0;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2.5 clk = ~clk;

    banked_ram i_banked_ram (
        .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rd_a), .bank_en(en_a)
    );

    banked_ram #(.MAX_DEPTH(512)) i_banked_ram_eight (
        .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rd_b), .bank_en(en_b)
    );

    banked_ram #(.MODE(SPLIT_WIDTH)) i_banked_ram_slice (
        .clk(clk), .rst_n(rst_n), .ce(ce), .we(we), .addr(addr),
        .wdata(wdata), .rdata(rd_c), .bank_en(en_c)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_en_depth(input logic c, input logic [11:0] a, input int shift);
        return c ? (32'd1 << (a >> shift)) : 32'd0;
    endfunction

    // one access: inputs at the falling edge, enables checked at once,
    // read data checked just after the following rising edge
    task automatic step(input logic c, input logic w, input logic [11:0] a,
                        input logic [3:0] d, input string tag);
        string etag, rtag;
        @(negedge clk);
        ce = c; we = w; addr = a; wdata = d;
        #1;
        etag = (tag != "") ? tag : (c ? "R2" : "R3");
        chk(32'(en_a) == exp_en_depth(c, a, 10), etag, 32'(en_a), exp_en_depth(c, a, 10));
        chk(32'(en_b) == exp_en_depth(c, a, 9), "R8", 32'(en_b), exp_en_depth(c, a, 9));
        chk(en_c == (c ? 4'hF : 4'h0), "R9", 32'(en_c), c ? 32'hF : 32'h0);
        if (c && !w) exp_rd = model[a];
        if (c && w)  model[a] = d;
        @(posedge clk);
        #1;
        rtag = (tag != "") ? tag : ((c && !w) ? "R5" : (c ? "R6" : "R3"));
        chk(rd_a == exp_rd, rtag, 32'(rd_a), 32'(exp_rd));
        chk(rd_b == exp_rd, "R8", 32'(rd_b), 32'(exp_rd));
        chk(rd_c == exp_rd, "R9", 32'(rd_c), 32'(exp_rd));
    endtask

    initial begin
        #(5.0 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        // R7: reset state
        repeat (3) @(posedge clk);
        #1;
        chk(rd_a == 4'h0, "R7", 32'(rd_a), 32'h0);
        chk(rd_b == 4'h0, "R7", 32'(rd_b), 32'h0);
        chk(rd_c == 4'h0, "R7", 32'(rd_c), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: fill the whole array and read every word back
        for (int i = 0; i < 4096; i++) step(1'b1, 1'b1, 12'(i), 4'((i * 7 + 3) ^ (i >> 4)), "R1");
        for (int i = 0; i < 4096; i++) step(1'b1, 1'b0, 12'(i), 4'h0, "R1");

        // R4: same offset in every bank, distinct data, then read all
        for (int b = 0; b < 4; b++) step(1'b1, 1'b1, 12'(b * 1024 + 37), 4'(b + 9), "R4");
        for (int b = 0; b < 4; b++) step(1'b1, 1'b0, 12'(b * 1024 + 37), 4'h0, "R4");

        // R3: write with ce low must not land, read data holds
        step(1'b1, 1'b0, 12'd1024, 4'h0, "");
        step(1'b0, 1'b1, 12'd1024, ~model[1024], "R3");
        step(1'b0, 1'b0, 12'd4095, 4'h0, "R3");
        step(1'b1, 1'b0, 12'd1024, 4'h0, "R3");

        // R6: write into another bank right after a read keeps rdata
        step(1'b1, 1'b0, 12'd4095, 4'h0, "");
        step(1'b1, 1'b1, 12'd0, 4'hA, "R6");
        step(1'b1, 1'b1, 12'd1023, 4'h5, "R6");

        // R5 boundaries: bank edges back to back
        step(1'b1, 1'b0, 12'd1023, 4'h0, "R5");
        step(1'b1, 1'b0, 12'd1024, 4'h0, "R5");
        step(1'b1, 1'b0, 12'd0, 4'h0, "R5");
        step(1'b1, 1'b0, 12'd4095, 4'h0, "R5");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic       c = ($urandom % 8) != 0;
            logic       w = ($urandom % 3) == 0;
            logic [11:0] a = 12'($urandom);
            logic [3:0]  d = 4'($urandom);
            step(c, w, a, d, "");
        end

        // R7: reset again in the middle of operation
        @(negedge clk);
        ce = 1'b0; rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk(rd_a == 4'h0, "R7", 32'(rd_a), 32'h0);
        chk(rd_c == 4'h0, "R7", 32'(rd_c), 32'h0);
        exp_rd = 4'h0;
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, 1'b0, 12'd2047, 4'h0, "R1");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule